// File: doc/BRIEF.md
# Table-Driven AXI4-Lite Register File

This block is an AXI4-Lite subordinate that holds a parameterized table of 32-bit registers. Each table entry sets a word address, an access mode, a starting value and a flag that says whether the register can raise an interrupt. Addresses in the table may leave gaps. A bus access that lands in a gap is refused with a response code chosen by parameter. A write to a register that the bus may not change is refused with a slave error.

Fabric logic reaches every register through its own port slice. It sees the current value of each register, and it can load a register through a per-register strobe with a data word. When the bus completes a read or a write on a table register, the block raises a one-cycle hit pulse for that register, so the fabric can react to the software access. Accumulating registers OR in fabric data and are emptied either when the bus reads them or when the bus writes them.

The block adds two registers of its own. A match register collects one sticky bit per interrupt-capable entry. An enable register masks those bits before they reach the interrupt output. The interrupt output runs either as a single pulse or as a level.

Top module: `axil_regfile`

## Requirements
- R1: Decoding uses address bits [DEC_W-1:2] and ignores bits [1:0]. A read or write whose address matches no table entry, the enable register or the match register returns ERR_RESP (default 2'b11, decode error) and changes nothing. A refused read returns data 0 and raises no hit.
- R2: A bus write to a constant (mode 0), read-only (mode 1) or read-clear accumulating (mode 3) register, or to the match register, returns 2'b10 (slave error) and leaves the value unchanged. Permitted accesses return 2'b00.
- R3: One cycle after the block accepts a permitted write to table entry i, bus_wr_hit[i] is high for exactly one cycle. One cycle after it accepts a read of entry i, bus_rd_hit[i] is high for exactly one cycle. At most one bit of each vector is high at a time, and accesses to the enable or match register, as well as refused accesses, raise no hit.
- R4: With IGNORE_HIGH set, address bits at and above DEC_W are ignored. DEC_W is the smallest width that reaches the highest configured address. With the default table, DEC_W is 6.
- R5: Reset is synchronous and active high. With INIT_ON_RESET set, every table register returns to its starting value. With it clear, reset leaves table register contents as they were.
- R6: A read-write register (mode 2) takes bus write data one byte lane at a time, where s_wstrb bit b enables bits [8b+7:8b]. Its value appears on fab_rdata. A fabric strobe loads the whole word, and the fabric strobe wins over a bus write in the same cycle.
- R7: A constant register always reads its starting value. A read-only register loads fab_wdata when its fab_wstb bit is high.
- R8: An accumulating register ORs in fabric data on each strobe. Mode 3 clears when the bus reads it, and the read returns the value from before the clear. Mode 4 clears when the bus writes it, and the write data is ignored. Bits set by the fabric in the same cycle as a clear are kept.
- R9: A fabric strobe that carries nonzero data into the k-th interrupt-flagged entry, counted in table order, sets bit k of the match register (default address 0x04). Match bits are sticky and clear when the bus reads the match register.
- R10: The enable register (default address 0x00) resets to 0xFFFFFFFF and takes byte-lane writes. A source whose enable bit is 0 still sets its match bit but does not drive irq.
- R11: With IRQ_PULSE clear, irq is high while any enabled match bit is set, starting the cycle after that bit is set.
- R12: With IRQ_PULSE set, irq pulses for one cycle, two cycles after an enabled match bit becomes set. No further pulse is issued until the bus has read the match register.
- R13: s_awready and s_wready rise together, and only when both valid signals are high and no write response is pending. s_arready is low while a read response is pending. A pending response and its code stay stable until the manager accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq | output | 1 | Interrupt request, pulse or level |
| fab_wdata | input | N_REGS*32 | Fabric data, one word per register |
| fab_wstb | input | N_REGS | Fabric load strobe per register |
| fab_rdata | output | N_REGS*32 | Current value of every register |
| bus_wr_hit | output | N_REGS | One-cycle pulse after a permitted bus write per register |
| bus_rd_hit | output | N_REGS | One-cycle pulse after a bus read per register |

## Verification
Two events can fall in the same cycle. A bus read can empty a read-clear accumulator while a fabric strobe sets new bits in it, and a bus write to a read-write register can meet a fabric load of that register. The bench sets the bus valid signal and the fabric strobe on the same falling edge, so that both take effect at the next rising edge. It then judges the result from two sides: the read data must hold the value from before the clear, and fab_rdata must hold only the fabric word. The same alignment is used for the write collision, where the fabric word must win over the bus data.

// File: rtl/axil_rf_pkg.sv
`timescale 1ns/1ps
package axil_rf_pkg;

    typedef enum logic [2:0] {
        MODE_CONST     = 3'd0,
        MODE_RO        = 3'd1,
        MODE_RW        = 3'd2,
        MODE_ACC_RDCLR = 3'd3,
        MODE_ACC_WRCLR = 3'd4
    } reg_mode_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    function automatic logic [31:0] lane_merge(logic [31:0] old_w, logic [31:0] new_w,
                                               logic [3:0] lanes);
        logic [31:0] res;
        res = old_w;
        for (int b = 0; b < 4; b++) begin
            if (lanes[b]) res[8*b +: 8] = new_w[8*b +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/axil_rf_decode.sv
`timescale 1ns/1ps
module axil_rf_decode #(
    parameter int                      N_REGS      = 5,
    parameter int                      ADDR_W      = 32,
    parameter int                      DEC_W       = 6,
    parameter bit                      IGNORE_HIGH = 1'b1,
    parameter logic [N_REGS*32-1:0]    REG_ADDR    = '0,
    parameter logic [31:0]             EN_ADDR     = 32'h0,
    parameter logic [31:0]             MR_ADDR     = 32'h4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REGS-1:0] sel,
    output logic              sel_en,
    output logic              sel_mr,
    output logic              miss
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] KEEP_MASK = IGNORE_HIGH ?
        (ADDR_W'((64'd1 << DEC_W) - 64'd1) & WORD_MASK) : WORD_MASK;

    logic [ADDR_W-1:0] key;
    assign key = addr & KEEP_MASK;

    for (genvar i = 0; i < N_REGS; i++) begin : g_cmp
        assign sel[i] = (key == (ADDR_W'(REG_ADDR[i*32 +: 32]) & KEEP_MASK));
    end

    assign sel_en = (key == (ADDR_W'(EN_ADDR) & KEEP_MASK));
    assign sel_mr = (key == (ADDR_W'(MR_ADDR) & KEEP_MASK));
    assign miss   = ~(|sel | sel_en | sel_mr);
endmodule

// File: rtl/axil_rf_cell.sv
`timescale 1ns/1ps
module axil_rf_cell
    import axil_rf_pkg::*;
#(
    parameter reg_mode_e   MODE          = MODE_RW,
    parameter logic [31:0] INIT          = 32'h0,
    parameter bit          INIT_ON_RESET = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_wstrb,
    input  logic        bus_rd,
    input  logic        fab_stb,
    input  logic [31:0] fab_data,
    output logic [31:0] value
);
    logic [31:0] val_d, val_q;
    logic        clr;

    assign clr = (MODE == MODE_ACC_RDCLR) ? bus_rd : bus_we;

    always_comb begin
        val_d = val_q;
        if (MODE == MODE_RO) begin
            if (fab_stb) val_d = fab_data;
        end else if (MODE == MODE_RW) begin
            if (bus_we)  val_d = lane_merge(val_q, bus_wdata, bus_wstrb);
            if (fab_stb) val_d = fab_data;
        end else begin
            val_d = (clr ? 32'h0 : val_q) | (fab_stb ? fab_data : 32'h0);
        end
    end

    always_ff @(posedge clk) begin
        if (INIT_ON_RESET && rst) val_q <= INIT;
        else                      val_q <= val_d;
    end

    assign value = val_q;

    if (MODE == MODE_ACC_RDCLR || MODE == MODE_ACC_WRCLR) begin : g_acc_chk
        // R8: accumulated bits only leave on a clear
        assert_acc_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(clr)) |-> ((val_q & $past(val_q)) == $past(val_q)));
    end
endmodule

// File: rtl/axil_rf_irq.sv
`timescale 1ns/1ps
module axil_rf_irq #(
    parameter int NI        = 2,
    parameter bit IRQ_PULSE = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NI-1:0] evt,
    input  logic          en_we,
    input  logic [31:0]   en_wdata,
    input  logic [3:0]    en_wstrb,
    input  logic          mr_rd,
    output logic [31:0]   en_word,
    output logic [31:0]   mr_word,
    output logic          irq
);
    typedef struct packed {
        logic [31:0]   en;
        logic [NI-1:0] mr;
        logic          armed;
        logic          pulse;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       pending;

    assign pending = |(st_q.mr & st_q.en[NI-1:0]);

    always_comb begin
        st_d = st_q;
        if (en_we) st_d.en = axil_rf_pkg::lane_merge(st_q.en, en_wdata, en_wstrb);
        st_d.mr    = (mr_rd ? '0 : st_q.mr) | evt;
        st_d.pulse = IRQ_PULSE && st_q.armed && pending;
        st_d.armed = (st_q.armed && !st_d.pulse) || mr_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.en    <= '1;
            st_q.mr    <= '0;
            st_q.armed <= 1'b1;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_word = st_q.en;
    assign mr_word = 32'(st_q.mr);
    assign irq     = IRQ_PULSE ? st_q.pulse : pending;

    // R9: match bits are only removed by a read of the match register
    assert_match_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mr_rd)) |-> ((st_q.mr & $past(st_q.mr)) == $past(st_q.mr)));

    if (IRQ_PULSE) begin : g_pulse_chk
        // R12: a pulse lasts a single cycle
        assert_pulse_single_R12: assert property (@(posedge clk) disable iff (rst)
            irq |=> !irq);
    end
endmodule

// File: rtl/axil_regfile.sv
`timescale 1ns/1ps
module axil_regfile
    import axil_rf_pkg::*;
#(
    parameter int                   N_REGS        = 5,
    parameter int                   ADDR_W        = 32,
    parameter logic [N_REGS*32-1:0] REG_ADDR      = {32'h24, 32'h20, 32'h10, 32'h0C, 32'h08},
    parameter logic [N_REGS*3-1:0]  REG_MODE      = {3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    parameter logic [N_REGS*32-1:0] REG_INIT      = {32'h0, 32'h0, 32'h1234_5678, 32'h0, 32'h0000_0A51},
    parameter logic [N_REGS-1:0]    REG_IRQ       = 5'b11000,
    parameter logic [31:0]          EN_ADDR       = 32'h00,
    parameter logic [31:0]          MR_ADDR       = 32'h04,
    parameter logic [1:0]           ERR_RESP      = RESP_DECERR,
    parameter bit                   INIT_ON_RESET = 1'b1,
    parameter bit                   IGNORE_HIGH   = 1'b1,
    parameter bit                   IRQ_PULSE     = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      s_awaddr,
    input  logic                   s_awvalid,
    output logic                   s_awready,
    input  logic [31:0]            s_wdata,
    input  logic [3:0]             s_wstrb,
    input  logic                   s_wvalid,
    output logic                   s_wready,
    output logic [1:0]             s_bresp,
    output logic                   s_bvalid,
    input  logic                   s_bready,
    input  logic [ADDR_W-1:0]      s_araddr,
    input  logic                   s_arvalid,
    output logic                   s_arready,
    output logic [31:0]            s_rdata,
    output logic [1:0]             s_rresp,
    output logic                   s_rvalid,
    input  logic                   s_rready,
    output logic                   irq,
    input  logic [N_REGS*32-1:0]   fab_wdata,
    input  logic [N_REGS-1:0]      fab_wstb,
    output logic [N_REGS*32-1:0]   fab_rdata,
    output logic [N_REGS-1:0]      bus_wr_hit,
    output logic [N_REGS-1:0]      bus_rd_hit
);
    function automatic int calc_dec_w();
        logic [31:0] top_a;
        top_a = (EN_ADDR > MR_ADDR) ? EN_ADDR : MR_ADDR;
        for (int i = 0; i < N_REGS; i++) begin
            if (REG_ADDR[i*32 +: 32] > top_a) top_a = REG_ADDR[i*32 +: 32];
        end
        return $clog2(top_a + 32'd4);
    endfunction

    function automatic int irq_pos(int upto);
        int cnt;
        cnt = 0;
        for (int j = 0; j < upto; j++) cnt += int'(REG_IRQ[j]);
        return cnt;
    endfunction

    localparam int DEC_W   = calc_dec_w();
    localparam int NUM_IRQ = irq_pos(N_REGS);
    localparam int IRQ_W   = (NUM_IRQ > 0) ? NUM_IRQ : 1;

    typedef struct packed {
        logic              bvalid;
        logic [1:0]        bresp;
        logic              rvalid;
        logic [31:0]       rdata;
        logic [1:0]        rresp;
        logic [N_REGS-1:0] wr_hit;
        logic [N_REGS-1:0] rd_hit;
    } axi_state_t;

    axi_state_t        st_d, st_q;
    logic [N_REGS-1:0] wr_sel, rd_sel, writable;
    logic              wr_sel_en, wr_sel_mr, wr_miss;
    logic              rd_sel_en, rd_sel_mr, rd_miss;
    logic              wr_go, rd_go;
    logic [1:0]        wr_resp;
    logic [31:0]       rd_word, en_word, mr_word;
    logic [31:0]       vals [N_REGS];
    logic [IRQ_W-1:0]  irq_evt;

    axil_rf_decode #(
        .N_REGS(N_REGS), .ADDR_W(ADDR_W), .DEC_W(DEC_W), .IGNORE_HIGH(IGNORE_HIGH),
        .REG_ADDR(REG_ADDR), .EN_ADDR(EN_ADDR), .MR_ADDR(MR_ADDR)
    ) u_wr_dec (
        .addr(s_awaddr), .sel(wr_sel), .sel_en(wr_sel_en), .sel_mr(wr_sel_mr), .miss(wr_miss)
    );

    axil_rf_decode #(
        .N_REGS(N_REGS), .ADDR_W(ADDR_W), .DEC_W(DEC_W), .IGNORE_HIGH(IGNORE_HIGH),
        .REG_ADDR(REG_ADDR), .EN_ADDR(EN_ADDR), .MR_ADDR(MR_ADDR)
    ) u_rd_dec (
        .addr(s_araddr), .sel(rd_sel), .sel_en(rd_sel_en), .sel_mr(rd_sel_mr), .miss(rd_miss)
    );

    assign wr_go     = s_awvalid && s_wvalid && !st_q.bvalid;
    assign rd_go     = s_arvalid && !st_q.rvalid;
    assign s_awready = wr_go;
    assign s_wready  = wr_go;
    assign s_arready = !st_q.rvalid;

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam reg_mode_e MD = reg_mode_e'(REG_MODE[i*3 +: 3]);
        assign writable[i] = (MD == MODE_RW) || (MD == MODE_ACC_WRCLR);
        if (MD == MODE_CONST) begin : g_const
            assign vals[i] = REG_INIT[i*32 +: 32];
        end else begin : g_store
            axil_rf_cell #(
                .MODE(MD), .INIT(REG_INIT[i*32 +: 32]), .INIT_ON_RESET(INIT_ON_RESET)
            ) u_cell (
                .clk(clk), .rst(rst),
                .bus_we(wr_go && wr_sel[i]), .bus_wdata(s_wdata), .bus_wstrb(s_wstrb),
                .bus_rd(rd_go && rd_sel[i]),
                .fab_stb(fab_wstb[i]), .fab_data(fab_wdata[i*32 +: 32]),
                .value(vals[i])
            );
        end
        assign fab_rdata[i*32 +: 32] = vals[i];
        if (REG_IRQ[i]) begin : g_evt
            assign irq_evt[irq_pos(i)] = fab_wstb[i] && (|fab_wdata[i*32 +: 32]);
        end
    end

    if (NUM_IRQ == 0) begin : g_no_evt
        assign irq_evt = '0;
    end

    axil_rf_irq #(.NI(IRQ_W), .IRQ_PULSE(IRQ_PULSE)) u_irq (
        .clk(clk), .rst(rst), .evt(irq_evt),
        .en_we(wr_go && wr_sel_en), .en_wdata(s_wdata), .en_wstrb(s_wstrb),
        .mr_rd(rd_go && rd_sel_mr),
        .en_word(en_word), .mr_word(mr_word), .irq(irq)
    );

    always_comb begin
        rd_word = 32'h0;
        for (int i = 0; i < N_REGS; i++) begin
            if (rd_sel[i]) rd_word = rd_word | vals[i];
        end
        if (rd_sel_en) rd_word = rd_word | en_word;
        if (rd_sel_mr) rd_word = rd_word | mr_word;
        if (wr_miss)                             wr_resp = ERR_RESP;
        else if (wr_sel_en || |(wr_sel & writable)) wr_resp = RESP_OKAY;
        else                                     wr_resp = RESP_SLVERR;
    end

    always_comb begin
        st_d        = st_q;
        st_d.wr_hit = '0;
        st_d.rd_hit = '0;
        if (st_q.bvalid && s_bready) st_d.bvalid = 1'b0;
        if (wr_go) begin
            st_d.bvalid = 1'b1;
            st_d.bresp  = wr_resp;
            st_d.wr_hit = wr_sel & writable;
        end
        if (st_q.rvalid && s_rready) st_d.rvalid = 1'b0;
        if (rd_go) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_miss ? 32'h0 : rd_word;
            st_d.rresp  = rd_miss ? ERR_RESP : RESP_OKAY;
            st_d.rd_hit = rd_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign s_bvalid   = st_q.bvalid;
    assign s_bresp    = st_q.bresp;
    assign s_rvalid   = st_q.rvalid;
    assign s_rdata    = st_q.rdata;
    assign s_rresp    = st_q.rresp;
    assign bus_wr_hit = st_q.wr_hit;
    assign bus_rd_hit = st_q.rd_hit;

    // R3: hit vectors carry at most one bit
    assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_wr_hit) && $onehot0(bus_rd_hit));
    // R3: a write hit accompanies its pending response
    assert_wr_hit_with_b_R3: assert property (@(posedge clk) disable iff (rst)
        (|bus_wr_hit) |-> s_bvalid);
    // R3: read hits never last two cycles
    assert_rd_hit_single_R3: assert property (@(posedge clk) disable iff (rst)
        (|bus_rd_hit) |=> (bus_rd_hit == '0));
    // R13: pending write response holds until taken
    assert_b_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
    // R13: pending read response holds until taken
    assert_r_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));
endmodule

// File: tb/test_axil_regfile.sv
`timescale 1ns/1ps
module test_axil_regfile;
    localparam int N = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   awaddr = '0, wdata = '0, araddr = '0;
    logic [3:0]    wstrb = '0;
    logic          awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, arvalid = 1'b0, rready = 1'b1;
    logic          awready, wready, bvalid, arready, rvalid, irq;
    logic [1:0]    bresp, rresp;
    logic [31:0]   rdata;
    logic [N*32-1:0] fab_wdata = '0;
    logic [N-1:0]  fab_wstb = '0;
    logic [N*32-1:0] fab_rdata, fab_rdata2;
    logic [N-1:0]  wr_hit, rd_hit, wr_hit2, rd_hit2;
    logic          awready2, wready2, bvalid2, arready2, rvalid2, irq2;
    logic [1:0]    bresp2, rresp2;
    logic [31:0]   rdata2;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    axil_regfile i_axil_regfile (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .irq(irq), .fab_wdata(fab_wdata), .fab_wstb(fab_wstb), .fab_rdata(fab_rdata),
        .bus_wr_hit(wr_hit), .bus_rd_hit(rd_hit)
    );

    axil_regfile #(.INIT_ON_RESET(1'b0), .IRQ_PULSE(1'b0)) i_axil_regfile_lvl (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready2),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready2),
        .s_bresp(bresp2), .s_bvalid(bvalid2), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready2),
        .s_rdata(rdata2), .s_rresp(rresp2), .s_rvalid(rvalid2), .s_rready(rready),
        .irq(irq2), .fab_wdata(fab_wdata), .fab_wstb(fab_wstb), .fab_rdata(fab_rdata2),
        .bus_wr_hit(wr_hit2), .bus_rd_hit(rd_hit2)
    );

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
        logic [31:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                          output logic [1:0] r, output logic [N-1:0] h);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        r = bresp; h = wr_hit;
    endtask

    task automatic axi_rd(input logic [31:0] a, output logic [31:0] d,
                          output logic [1:0] r, output logic [N-1:0] h);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(negedge clk);
        arvalid = 1'b0;
        d = rdata; r = rresp; h = rd_hit;
    endtask

    task automatic fab(input int i, input logic [31:0] v);
        @(negedge clk);
        fab_wstb[i] = 1'b1; fab_wdata[i*32 +: 32] = v;
        @(negedge clk);
        fab_wstb = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, rw_model;
        logic [1:0]  r;
        logic [N-1:0] h;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk("R5 irq after reset", 32'(irq), 0);
        axi_rd(32'h10, d, r, h); chk("R5 RW starting value", d, 32'h1234_5678);
        rw_model = 32'h1234_5678;
        axi_rd(32'h08, d, r, h); chk("R7 constant read", d, 32'h0000_0A51);
        axi_rd(32'h00, d, r, h); chk("R10 enable reset value", d, 32'hFFFF_FFFF);

        // holes
        axi_rd(32'h14, d, r, h);
        chk("R1 hole read resp", 32'(r), 32'h3); chk("R1 hole read data", d, 0);
        chk("R1 hole read no hit", 32'(h), 0);
        axi_wr(32'h18, 32'hFFFF_FFFF, 4'hF, r, h);
        chk("R1 hole write resp", 32'(r), 32'h3); chk("R1 hole write no hit", 32'(h), 0);

        // permission errors
        axi_wr(32'h08, 32'h1, 4'hF, r, h); chk("R2 const write resp", 32'(r), 32'h2);
        chk("R2 const write no hit", 32'(h), 0);
        axi_rd(32'h08, d, r, h); chk("R2 const unchanged", d, 32'h0000_0A51);
        axi_wr(32'h0C, 32'h1, 4'hF, r, h); chk("R2 ro write resp", 32'(r), 32'h2);
        axi_wr(32'h20, 32'h1, 4'hF, r, h); chk("R2 rdclr write resp", 32'(r), 32'h2);
        axi_wr(32'h04, 32'h1, 4'hF, r, h); chk("R2 match write resp", 32'(r), 32'h2);

        // hits and byte lanes
        axi_wr(32'h10, 32'hAABB_CCDD, 4'hF, r, h);
        rw_model = 32'hAABB_CCDD;
        chk("R3 write hit", 32'(h), 32'h04); chk("R2 rw write resp", 32'(r), 0);
        @(negedge clk); chk("R3 write hit one cycle", 32'(wr_hit), 0);
        axi_rd(32'h0C, d, r, h); chk("R3 read hit", 32'(h), 32'h02);
        @(negedge clk); chk("R3 read hit one cycle", 32'(rd_hit), 0);
        axi_wr(32'h10, 32'h1122_3344, 4'b0101, r, h);
        rw_model = merge(rw_model, 32'h1122_3344, 4'b0101);
        chk("R6 lane merge on port", fab_rdata[2*32 +: 32], 32'hAA22_CC44);

        // aliases through high bits
        axi_wr(32'hABCD_0010, 32'h0BAD_F00D, 4'hF, r, h);
        rw_model = 32'h0BAD_F00D;
        axi_rd(32'h4000_0010, d, r, h); chk("R4 alias read", d, 32'h0BAD_F00D);

        // random byte-lane traffic through random bases
        for (int k = 0; k < 30; k++) begin
            logic [31:0] wd, wa, ra, hole;
            logic [3:0]  ws;
            wd = $urandom; ws = 4'($urandom);
            wa = {$urandom, 6'h0} | 32'h10;
            ra = {$urandom, 6'h0} | 32'h10;
            axi_wr(wa, wd, ws, r, h);
            rw_model = merge(rw_model, wd, ws);
            chk("R6 random write resp", 32'(r), 0);
            axi_rd(ra, d, r, h); chk("R4 R6 random readback", d, rw_model);
            hole = {$urandom, 6'h0} | (32'h14 + 32'(4 * ($urandom % 3)));
            axi_rd(hole, d, r, h); chk("R1 random hole resp", 32'(r), 32'h3);
        end

        // read-only capture
        fab(1, 32'hCAFE_0001);
        axi_rd(32'h0C, d, r, h); chk("R7 ro capture", d, 32'hCAFE_0001);

        // fabric beats bus in the same cycle
        @(negedge clk);
        awaddr = 32'h10; wdata = 32'h1111_1111; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
        fab_wstb[2] = 1'b1; fab_wdata[2*32 +: 32] = 32'h5A5A_0F0F;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0; fab_wstb = '0;
        rw_model = 32'h5A5A_0F0F;
        chk("R6 fabric wins", fab_rdata[2*32 +: 32], 32'h5A5A_0F0F);

        // interrupt source 0 (read-clear accumulator)
        fab(3, 32'h0000_0005);
        chk("R11 level irq", 32'(irq2), 1); chk("R12 no pulse yet", 32'(irq), 0);
        @(negedge clk); chk("R12 pulse", 32'(irq), 1);
        @(negedge clk); chk("R12 pulse ends", 32'(irq), 0);
        fab(3, 32'h0000_0100);
        @(negedge clk); chk("R12 no repeat", 32'(irq), 0);
        @(negedge clk); chk("R12 no repeat later", 32'(irq), 0);
        axi_rd(32'h20, d, r, h); chk("R8 accumulate", d, 32'h0000_0105);
        axi_rd(32'h20, d, r, h); chk("R8 cleared by read", d, 0);
        axi_rd(32'h04, d, r, h); chk("R9 match bit0", d, 32'h1);
        axi_rd(32'h04, d, r, h); chk("R9 match cleared", d, 0);
        chk("R11 level drops", 32'(irq2), 0);

        // interrupt source 1 (write-clear accumulator), re-armed pulse
        fab(4, 32'h0000_0030);
        @(negedge clk); chk("R12 rearmed pulse", 32'(irq), 1);
        axi_rd(32'h04, d, r, h); chk("R9 match bit1", d, 32'h2);
        axi_wr(32'h24, 32'hFFFF_FFFF, 4'hF, r, h);
        chk("R8 wrclr resp", 32'(r), 0);
        chk("R8 wrclr ignores data", fab_rdata[4*32 +: 32], 0);

        // read-clear meets fabric set
        fab(3, 32'h0000_0007);
        @(negedge clk);
        araddr = 32'h20; arvalid = 1'b1;
        fab_wstb[3] = 1'b1; fab_wdata[3*32 +: 32] = 32'h0000_0040;
        @(negedge clk);
        arvalid = 1'b0; fab_wstb = '0;
        chk("R8 read returns pre-clear", rdata, 32'h7);
        chk("R8 same-cycle set kept", fab_rdata[3*32 +: 32], 32'h40);
        axi_rd(32'h04, d, r, h); chk("R9 match after collision", d, 32'h1);

        // masked source
        axi_wr(32'h00, 32'hFFFF_FFFE, 4'hF, r, h); chk("R10 enable write resp", 32'(r), 0);
        fab(3, 32'h1);
        chk("R10 masked level", 32'(irq2), 0);
        @(negedge clk); chk("R10 masked pulse", 32'(irq), 0);
        axi_rd(32'h04, d, r, h); chk("R10 masked still matches", d, 32'h1);
        axi_rd(32'h00, d, r, h); chk("R10 enable readback", d, 32'hFFFF_FFFE);

        // handshake
        bready = 1'b0;
        axi_wr(32'h10, 32'h0, 4'h0, r, h);
        @(negedge clk);
        awvalid = 1'b1; wvalid = 1'b1; #1;
        chk("R13 bvalid held", 32'(bvalid), 1);
        chk("R13 no accept while pending", 32'({awready, wready}), 0);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0; bready = 1'b1;
        @(negedge clk);
        awvalid = 1'b1; #1;
        chk("R13 address alone not taken", 32'(awready), 0);
        awvalid = 1'b0;
        rready = 1'b0;
        axi_rd(32'h08, d, r, h);
        @(negedge clk);
        chk("R13 rvalid held", 32'(rvalid), 1); chk("R13 arready low", 32'(arready), 0);
        chk("R13 rdata held", rdata, 32'h0000_0A51);
        rready = 1'b1;
        @(negedge clk);

        // reset reload versus keep
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R5 reload on reset", fab_rdata[2*32 +: 32], 32'h1234_5678);
        chk("R5 keep on reset", fab_rdata2[2*32 +: 32], rw_model);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule